// File: doc/BRIEF.md
# Multiprocessor-Capable Asynchronous Serial Receiver

This block turns a serial line into bytes. It watches for a falling edge on an idle-high line and times each bit using an external enable that pulses at sixteen times the bit rate. It takes one sample in the middle of every bit period. The receiver has two frame layouts. In normal mode a frame carries 7 data bits, plus a parity bit if parity is switched on. In multiprocessor mode a frame carries 8 data bits, followed by a flag bit that tells an address frame apart from a data frame.

When a frame ends, the receiver first records any parity, framing or overrun errors in sticky flags. In the next clock cycle it raises a receive-full flag. That flag drives the interrupt while the interrupt is enabled. A read strobe clears receive-full, and a separate pulse clears the error flags. The receiver checks only the first stop bit. Any further high time on the line counts as idle.

Top module: `uart_mp_rx`

## Requirements
- R1: With `rx_en` low the receiver stays idle. A whole frame sent in that time leaves `rx_full` at 0.
- R2: A low level counts as a start bit only if the line is still low at the middle of the start bit. A shorter low pulse is dropped and the receiver goes back to idle, ready for the next real frame.
- R3: Data bits arrive least significant bit first. With `mp_mode`=0 the frame holds 7 data bits, which appear on `rx_data[6:0]` with `rx_data[7]`=0.
- R4: With `mp_mode`=1 the frame holds 8 data bits on `rx_data[7:0]`, followed by one more bit. That bit is captured on `addr_flag`, where 1 means address and 0 means data.
- R5: With `mp_mode`=0 and `par_en`=1, a parity bit follows bit 6. It is checked over the 7 data bits plus the parity bit. `par_odd`=0 expects an even count of ones and `par_odd`=1 expects an odd count. A mismatch sets `perr`.
- R6: A low level at the middle of the first stop bit sets `ferr`. A second stop bit is treated as idle, so a new start bit may follow the first stop bit directly.
- R7: Error flags take their new values at least one clock cycle before `rx_full` rises.
- R8: If a frame completes while `rx_full` is 1, `oerr` is set and `rx_data` and `addr_flag` keep the earlier frame.
- R9: A one-cycle `rd_strobe` clears `rx_full`. `perr`, `ferr` and `oerr` stay set until `err_clr` is pulsed.
- R10: `irq` is 1 exactly when `irq_en` is 1 and `rx_full` is 1.
- R11: While reset is active and right after it, `rx_full`, all error flags and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | One-cycle enable at 16x the bit rate |
| rx_en | input | 1 | Receive enable |
| rxd | input | 1 | Serial input, idle high |
| mp_mode | input | 1 | 0 = normal mode (7 data bits), 1 = multiprocessor mode (8 data bits + address/data flag) |
| par_en | input | 1 | Parity bit present (normal mode only) |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| irq_en | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | Data read pulse; clears `rx_full` |
| err_clr | input | 1 | Pulse that clears all error flags |
| rx_data | output | 8 | Received data |
| addr_flag | output | 1 | Address/data bit of the last multiprocessor frame |
| rx_full | output | 1 | Received data waiting to be read |
| perr | output | 1 | Sticky parity error |
| ferr | output | 1 | Sticky framing error |
| oerr | output | 1 | Sticky overrun error |
| irq | output | 1 | Receive interrupt |

## Verification
A bit counter or frame-length choice that is wrong shows up within one frame. The data comes out shifted, or a data bit is taken as the stop bit, and then `rx_data` and `ferr` no longer match the scoreboard entry at the next rising edge of `rx_full`. A start-detect state that is stuck or wrongly timed either produces a frame nobody sent, which the monitor reports as having no expected entry, or loses the frame that follows a glitch. Mistakes in the flag handling show up within a single clock of the frame ending, through the order of flags against `rx_full`, through `oerr`, and through data that should have been held.

// File: rtl/uart_mp_rx_pkg.sv
package uart_mp_rx_pkg;
  localparam int SHIFT_W = 9;
  localparam int DATA_W  = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BITS,
    ST_STOP,
    ST_DONE
  } rx_state_e;

  function automatic logic [3:0] frame_len(input logic mp, input logic par);
    if (mp)       return 4'd9;
    else if (par) return 4'd8;
    else          return 4'd7;
  endfunction
endpackage

// File: rtl/uart_mp_rx_sync.sv
module uart_mp_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart_mp_rx_frame.sv
module uart_mp_rx_frame
  import uart_mp_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_en,
  input  logic              rxs,
  input  logic              mp_mode,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              frm_end,
  output logic              frm_done,
  output logic [DATA_W-1:0] frm_data,
  output logic              frm_ad,
  output logic              frm_perr,
  output logic              frm_ferr,
  output rx_state_e         state_o
);
  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;

  rx_state_e          st_q, st_d;
  logic [CW-1:0]      os_q, os_d;
  logic [3:0]         bit_q, bit_d;
  logic [SHIFT_W-1:0] sh_q, sh_d;
  logic [3:0]         nbits;
  logic [SHIFT_W-1:0] aligned;
  logic               os_last;

  assign nbits   = frame_len(mp_mode, par_en);
  assign os_last = (os_q == CW'(OVS - 1));

  always_comb begin
    st_d    = st_q;
    os_d    = os_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    frm_end = 1'b0;
    if (!rx_en && st_q != ST_DONE) begin
      st_d  = ST_IDLE;
      os_d  = '0;
      bit_d = '0;
    end else begin
      case (st_q)
        ST_IDLE: if (tick && !rxs) begin
          st_d = ST_START;
          os_d = '0;
        end
        ST_START: if (tick) begin
          if (os_q == CW'(HALF - 1)) begin
            os_d  = '0;
            bit_d = '0;
            st_d  = rxs ? ST_IDLE : ST_BITS;
          end else begin
            os_d = os_q + 1'b1;
          end
        end
        ST_BITS: if (tick) begin
          if (os_last) begin
            os_d  = '0;
            sh_d  = {rxs, sh_q[SHIFT_W-1:1]};
            bit_d = bit_q + 4'd1;
            if (bit_q == nbits - 4'd1) st_d = ST_STOP;
          end else begin
            os_d = os_q + 1'b1;
          end
        end
        ST_STOP: if (tick) begin
          if (os_last) begin
            os_d    = '0;
            frm_end = 1'b1;
            st_d    = ST_DONE;
          end else begin
            os_d = os_q + 1'b1;
          end
        end
        ST_DONE: st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      os_q  <= '0;
      bit_q <= '0;
      sh_q  <= '0;
    end else begin
      st_q  <= st_d;
      os_q  <= os_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
    end
  end

  assign aligned  = sh_q >> (4'(SHIFT_W) - nbits);
  assign frm_data = mp_mode ? aligned[7:0] : {1'b0, aligned[6:0]};
  assign frm_ad   = mp_mode & aligned[8];
  assign frm_perr = !mp_mode && par_en && ((^aligned[7:0]) != par_odd);
  assign frm_ferr = !rxs;
  assign frm_done = (st_q == ST_DONE);
  assign state_o  = st_q;
endmodule

// File: rtl/uart_mp_rx_flags.sv
module uart_mp_rx_flags
  import uart_mp_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_end,
  input  logic              frm_done,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              frm_ad,
  input  logic              frm_perr,
  input  logic              frm_ferr,
  input  logic              rd_strobe,
  input  logic              err_clr,
  output logic [DATA_W-1:0] data_o,
  output logic              ad_o,
  output logic              full_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              oerr_o
);
  logic [DATA_W-1:0] data_q, data_d;
  logic ad_q, ad_d, full_q, full_d, pend_q, pend_d;
  logic perr_q, perr_d, ferr_q, ferr_d, oerr_q, oerr_d;

  always_comb begin
    data_d = data_q;
    ad_d   = ad_q;
    full_d = full_q;
    pend_d = pend_q;
    perr_d = perr_q;
    ferr_d = ferr_q;
    oerr_d = oerr_q;
    if (err_clr) begin
      perr_d = 1'b0;
      ferr_d = 1'b0;
      oerr_d = 1'b0;
    end
    if (frm_end) begin
      perr_d = perr_d | frm_perr;
      ferr_d = ferr_d | frm_ferr;
      if (full_q) begin
        oerr_d = 1'b1;
      end else begin
        data_d = frm_data;
        ad_d   = frm_ad;
        pend_d = 1'b1;
      end
    end
    if (rd_strobe) full_d = 1'b0;
    if (frm_done && pend_q) begin
      full_d = 1'b1;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ad_q   <= 1'b0;
      full_q <= 1'b0;
      pend_q <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      oerr_q <= 1'b0;
    end else begin
      data_q <= data_d;
      ad_q   <= ad_d;
      full_q <= full_d;
      pend_q <= pend_d;
      perr_q <= perr_d;
      ferr_q <= ferr_d;
      oerr_q <= oerr_d;
    end
  end

  assign data_o = data_q;
  assign ad_o   = ad_q;
  assign full_o = full_q;
  assign perr_o = perr_q;
  assign ferr_o = ferr_q;
  assign oerr_o = oerr_q;
endmodule

// File: rtl/uart_mp_rx.sv
module uart_mp_rx
  import uart_mp_rx_pkg::*;
#(
  parameter int OVS        = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rx_en,
  input  logic       rxd,
  input  logic       mp_mode,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       irq_en,
  input  logic       rd_strobe,
  input  logic       err_clr,
  output logic [7:0] rx_data,
  output logic       addr_flag,
  output logic       rx_full,
  output logic       perr,
  output logic       ferr,
  output logic       oerr,
  output logic       irq
);
  logic              rxs;
  logic              frm_end, frm_done, frm_ad, frm_perr, frm_ferr;
  logic [DATA_W-1:0] frm_data;
  rx_state_e         rx_state;

  uart_mp_rx_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxs)
  );

  uart_mp_rx_frame #(.OVS(OVS)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx_en(rx_en), .rxs(rxs),
    .mp_mode(mp_mode), .par_en(par_en), .par_odd(par_odd),
    .frm_end(frm_end), .frm_done(frm_done), .frm_data(frm_data),
    .frm_ad(frm_ad), .frm_perr(frm_perr), .frm_ferr(frm_ferr),
    .state_o(rx_state)
  );

  uart_mp_rx_flags u_flags (
    .clk(clk), .rst_n(rst_n), .frm_end(frm_end), .frm_done(frm_done),
    .frm_data(frm_data), .frm_ad(frm_ad), .frm_perr(frm_perr),
    .frm_ferr(frm_ferr), .rd_strobe(rd_strobe), .err_clr(err_clr),
    .data_o(rx_data), .ad_o(addr_flag), .full_o(rx_full),
    .perr_o(perr), .ferr_o(ferr), .oerr_o(oerr)
  );

  assign irq = irq_en & rx_full;
endmodule

// File: rtl/uart_mp_rx_chk.sv
module uart_mp_rx_chk
  import uart_mp_rx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       rd_strobe,
  input logic       err_clr,
  input logic       rx_full,
  input logic [7:0] rx_data,
  input logic       addr_flag,
  input logic       perr,
  input logic       ferr,
  input logic       oerr,
  input logic       frm_end,
  input logic       frm_done,
  input rx_state_e  rx_state
);
  a_r1_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> rx_state == ST_IDLE);

  a_r7_flags_settled: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_full) && !$past(err_clr)) |-> ($stable(perr) && $stable(ferr) && $stable(oerr)));

  a_r8_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rd_strobe) |=> (rx_full && $stable(rx_data) && $stable(addr_flag)));

  a_r8_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_end && rx_full) |=> oerr);

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !frm_done) |=> !rx_full);

  a_r9_perr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (perr && !err_clr) |=> perr);

  a_r9_ferr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ferr && !err_clr) |=> ferr);

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !frm_end) |=> (!perr && !ferr && !oerr));
endmodule

bind uart_mp_rx uart_mp_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rd_strobe(rd_strobe),
  .err_clr(err_clr), .rx_full(rx_full), .rx_data(rx_data),
  .addr_flag(addr_flag), .perr(perr), .ferr(ferr), .oerr(oerr),
  .frm_end(frm_end), .frm_done(frm_done), .rx_state(rx_state)
);

// File: tb/uart_mp_rx_bench.sv
module uart_mp_rx_bench;
  localparam int TDIV = 4;
  localparam int OVS  = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] tdiv;
  logic os_tick, rx_en, rxd, mp_mode, par_en, par_odd, irq_en, rd_strobe, err_clr;
  logic [7:0] rx_data;
  logic addr_flag, rx_full, perr, ferr, oerr, irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [10:0] exp_q[$];
  logic [10:0] e;
  bit auto_rd, force_rd;
  logic prev_full;
  logic [1:0] prev_flags;

  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) tdiv <= '0;
    else        tdiv <= tdiv + 2'd1;
  assign os_tick = (tdiv == 2'd0);

  uart_mp_rx u_uart_mp_rx (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_en(rx_en), .rxd(rxd),
    .mp_mode(mp_mode), .par_en(par_en), .par_odd(par_odd), .irq_en(irq_en),
    .rd_strobe(rd_strobe), .err_clr(err_clr), .rx_data(rx_data),
    .addr_flag(addr_flag), .rx_full(rx_full), .perr(perr), .ferr(ferr),
    .oerr(oerr), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares each received frame against the scoreboard and reads it
  always @(negedge clk) begin
    if (!rst_n) begin
      rd_strobe  <= 1'b0;
      err_clr    <= 1'b0;
      prev_full  <= 1'b0;
      prev_flags <= 2'b00;
    end else begin
      if (rd_strobe) begin
        rd_strobe <= 1'b0;
        err_clr   <= 1'b0;
      end else if (auto_rd && rx_full && !prev_full) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1/R2 frame with no expected entry", {24'd0, rx_data}, 0);
        end else begin
          e = exp_q.pop_front();
          chk(rx_data == e[7:0], "R3 data", rx_data, e[7:0]);
          chk(addr_flag == e[8], "R4 addr_flag", addr_flag, e[8]);
          chk(perr == e[9], "R5 perr", perr, e[9]);
          chk(ferr == e[10], "R6 ferr", ferr, e[10]);
          chk(prev_flags == e[10:9], "R7 flags one cycle before full", prev_flags, e[10:9]);
          chk(irq == irq_en, "R10 irq", irq, irq_en);
        end
        rd_strobe <= 1'b1;
        err_clr   <= 1'b1;
      end else if (force_rd && rx_full) begin
        rd_strobe <= 1'b1;
        err_clr   <= 1'b1;
      end
      prev_full  <= rx_full;
      prev_flags <= {ferr, perr};
    end
  end

  task automatic drive_bit(input logic v, input int ticks);
    rxd = v;
    repeat (ticks * TDIV) @(negedge clk);
  endtask

  task automatic send_bits(input logic [8:0] b, input int n, input bit stop_ok,
                           input int nstop, input int gap);
    drive_bit(1'b0, OVS);
    for (int i = 0; i < n; i++) drive_bit(b[i], OVS);
    if (stop_ok) drive_bit(1'b1, OVS * nstop);
    else begin
      drive_bit(1'b0, 12);
      drive_bit(1'b1, 4 + OVS * (nstop - 1));
    end
    if (gap > 0) drive_bit(1'b1, gap);
  endtask

  // pm: 0 none, 1 even, 2 odd
  task automatic send_norm(input logic [6:0] d, input int pm, input bit flip,
                           input bit stop_ok, input int nstop, input int gap, input bit push);
    logic p;
    mp_mode = 1'b0;
    par_en  = (pm != 0);
    par_odd = (pm == 2);
    p = (^d) ^ (pm == 2) ^ flip;
    if (push) exp_q.push_back({~stop_ok, flip && (pm != 0), 1'b0, 1'b0, d});
    send_bits({1'b0, p, d}, (pm != 0) ? 8 : 7, stop_ok, nstop, gap);
  endtask

  task automatic send_mp(input logic [7:0] d, input logic ad, input bit push);
    mp_mode = 1'b1;
    par_en  = 1'b0;
    par_odd = 1'b0;
    if (push) exp_q.push_back({1'b0, 1'b0, ad, d});
    send_bits({ad, d}, 9, 1'b1, 1, 2 * OVS);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 180000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rxd = 1'b1; rx_en = 1'b1; mp_mode = 1'b0; par_en = 1'b0;
    par_odd = 1'b0; irq_en = 1'b1; auto_rd = 1'b1; force_rd = 1'b0;
    repeat (5) @(negedge clk);
    chk({rx_full, perr, ferr, oerr, irq} == 5'd0, "R11 reset state", {rx_full, perr, ferr, oerr, irq}, 0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk({rx_full, perr, ferr, oerr, irq} == 5'd0, "R11 after release", {rx_full, perr, ferr, oerr, irq}, 0);

    // R3 normal frames
    send_norm(7'h55, 0, 0, 1, 1, 32, 1);
    send_norm(7'h0E, 0, 0, 1, 1, 32, 1);
    // R6 two stop bits followed directly by a frame
    send_norm(7'h2A, 0, 0, 1, 2, 0, 1);
    send_norm(7'h7F, 0, 0, 1, 1, 32, 1);
    // R5 parity
    send_norm(7'h31, 1, 0, 1, 1, 32, 1);
    send_norm(7'h31, 2, 0, 1, 1, 32, 1);
    send_norm(7'h31, 2, 1, 1, 1, 32, 1);
    send_norm(7'h6C, 1, 1, 1, 1, 32, 1);
    // R4 multiprocessor
    send_mp(8'hA5, 1'b1, 1);
    send_mp(8'h3C, 1'b0, 1);
    send_mp(8'hFF, 1'b1, 1);
    // R6 framing error
    send_norm(7'h12, 0, 0, 0, 1, 32, 1);
    chk(exp_q.size() == 0, "R6 recovery after bad stop", exp_q.size(), 0);

    // R1 receiver disabled
    rx_en = 1'b0;
    send_norm(7'h33, 0, 0, 1, 1, 32, 0);
    chk(rx_full == 1'b0, "R1 disabled frame ignored", rx_full, 0);
    rx_en = 1'b1;
    drive_bit(1'b1, 16);

    // R2 glitch rejected
    drive_bit(1'b0, 5);
    drive_bit(1'b1, 40);
    chk(rx_full == 1'b0, "R2 glitch rejected", rx_full, 0);
    send_norm(7'h44, 0, 0, 1, 1, 32, 1);

    // R10 irq disabled
    irq_en = 1'b0;
    send_mp(8'h81, 1'b0, 1);
    irq_en = 1'b1;

    // R8 overrun
    auto_rd = 1'b0;
    send_norm(7'h4B, 0, 0, 1, 1, 32, 0);
    chk(rx_full == 1'b1, "R9 full held without read", rx_full, 1);
    chk(irq == 1'b1, "R10 irq while full", irq, 1);
    send_norm(7'h21, 0, 0, 1, 1, 32, 0);
    chk(oerr == 1'b1, "R8 overrun flag", oerr, 1);
    chk(rx_data == 8'h4B, "R8 earlier data kept", rx_data, 8'h4B);
    drive_bit(1'b1, 32);
    chk(oerr == 1'b1, "R9 oerr sticky", oerr, 1);
    force_rd = 1'b1;
    repeat (4) @(negedge clk);
    force_rd = 1'b0;
    chk(rx_full == 1'b0, "R9 read clears full", rx_full, 0);
    chk(oerr == 1'b0, "R9 err_clr clears oerr", oerr, 0);
    chk(irq == 1'b0, "R10 irq drops", irq, 0);
    auto_rd = 1'b1;

    send_norm(7'h5A, 1, 0, 1, 1, 32, 1);
    repeat (100) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all frames received", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule